// File: doc/BRIEF.md
# Conversion Start/Stop Sequencer

This block decides when an ADC conversion begins and when a stream of conversions ends. The host writes one 8-bit control word. The upper six bits carry a reset key. Bit 1 asks for a start and bit 0 asks for a stop. The block issues a one-clock start pulse to the modulator and holds a busy level while a conversion is in flight. It issues an abort pulse when a conversion in flight is thrown away. It counts completed conversions in a rolling counter and raises a data-ready flag that the host clears by reading the result.

Two modes are supported, selected by a mode input. In single-shot mode each start produces exactly one conversion. In continuous mode the block restarts the modulator after every completion until the host stops it. A stop request does not cut a conversion short: the request stays pending, and reads back as pending, until that conversion finishes. A power-down input ends activity at once. A correctly keyed control write asks the rest of the chip for a soft reset.

Top module: `conv_seq`

## Requirements
- R1: A write whose bits 7:2 equal 010110b and whose bits 1:0 are both 0 drives `soft_rst_req` high for exactly the next cycle. In that cycle the block is idle, the counter reads Fh and data-ready is 0. Any other value in bits 7:2, or a set START or STOP bit, does not request a reset.
- R2: `ctl_rd_data` bits 7:1 always read 0. Bit 0 reads 1 exactly while a stop request is pending.
- R3: A write with bit 1 = 1 and bit 0 = 0 makes `conv_start` high for one cycle, in the cycle after the write. `conv_busy` rises in that same cycle. In single-shot mode `conv_busy` falls in the cycle after the completion pulse.
- R4: In continuous mode, a completion with no stop pending and no stop being written raises `conv_start` in the next cycle, and `conv_busy` stays high.
- R5: A start written while busy makes `conv_abort` high for one cycle and begins a new conversion. A completion pulse arriving on the same edge is discarded.
- R6: A write with bits 1:0 = 11b changes nothing.
- R7: In continuous mode, a stop written while busy sets the pending bit. The current conversion completes and is counted, and then busy falls. In single-shot mode, or when idle, a stop has no effect.
- R8: A start written while a stop is pending clears the pending bit.
- R9: The counter reads Fh after reset and reads 0h after the first completion. It adds one on each completion and wraps from Fh to 0h.
- R10: Data-ready sets on each completion and clears when `result_rd` is sampled high. If both happen on the same edge, data-ready ends up set.
- R11: While `pwr_down` is high, any conversion is aborted, the block goes idle, the counter is held at Fh and data-ready is held at 0. Start writes are ignored.
- R12: When several events fall on the same edge, they take priority in this order: keyed reset, then power-down, then start, then completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 8 | Control word: key in 7:2, START in 1, STOP in 0 |
| ctl_rd_data | output | 8 | Control word readback |
| cont_mode | input | 1 | 1 = continuous, 0 = single-shot |
| pwr_down | input | 1 | Power-down level |
| conv_done | input | 1 | Completion pulse from the modulator |
| result_rd | input | 1 | Host read of the conversion result |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_busy | output | 1 | Conversion in flight |
| conv_abort | output | 1 | One-cycle pulse when a conversion is dropped |
| soft_rst_req | output | 1 | One-cycle soft reset request |
| conv_count | output | 4 | Rolling completion counter |
| data_rdy | output | 1 | New result not yet read |

## Verification
A corrupted sequencer state shows up within one cycle of the next event. A missing or extra `conv_start` appears right after a completion or a write. A stuck pending stop appears on the readback bit. A counter that skips or misses a wrap appears at the next completion. A reference model in the bench is stepped on every clock and compared against all outputs. Directed sequences then push the same-edge collisions: restart against completion, completion against result read, and keyed reset against power-down. These are the cases where a wrong priority shows up as a wrong count, a lost data-ready or a missing abort.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_ONE  = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic key_rst;
      logic go;
      logic halt;
   } seq_cmd_t;

endpackage

// File: rtl/conv_seq_cmd_dec.sv
module conv_seq_cmd_dec
   import conv_seq_pkg::*;
#(
   parameter int CTRL_W = 8,
   parameter int KEY_W  = 6,
   parameter logic [KEY_W-1:0] KEY = 6'b010110
) (
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output seq_cmd_t          cmd
);
   localparam int KEY_LSB = CTRL_W - KEY_W;

   if (KEY_LSB != 2) begin : g_bad_layout
      $error("control word must hold the key above exactly two command bits");
   end

   logic [KEY_W-1:0] bit_eq;
   logic             go_bit;
   logic             halt_bit;

   assign go_bit   = wr_data[1];
   assign halt_bit = wr_data[0];

   for (genvar i = 0; i < KEY_W; i++) begin : g_key
      assign bit_eq[i] = ~(wr_data[KEY_LSB+i] ^ KEY[i]);
   end

   always_comb begin
      cmd.key_rst = wr_en && (&bit_eq) && !go_bit && !halt_bit;
      cmd.go      = wr_en && go_bit && !halt_bit;
      cmd.halt    = wr_en && halt_bit && !go_bit;
   end
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
   import conv_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  seq_cmd_t cmd,
   input  logic     cont_mode,
   input  logic     pwr_down,
   input  logic     conv_done,
   output logic     conv_start,
   output logic     conv_busy,
   output logic     conv_abort,
   output logic     soft_rst_req,
   output logic     stop_pend,
   output logic     done_ok,
   output logic     flush
);
   seq_state_e state_q;
   logic       keep_running;

   assign conv_busy    = (state_q != SEQ_IDLE);
   assign flush        = cmd.key_rst || pwr_down;
   assign done_ok      = !flush && !cmd.go && conv_done && conv_busy;
   assign keep_running = (state_q == SEQ_RUN) && !stop_pend && !cmd.halt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SEQ_IDLE;
         conv_start   <= 1'b0;
         conv_abort   <= 1'b0;
         soft_rst_req <= 1'b0;
         stop_pend    <= 1'b0;
      end else begin
         conv_start   <= 1'b0;
         conv_abort   <= 1'b0;
         soft_rst_req <= cmd.key_rst;
         if (flush) begin
            state_q    <= SEQ_IDLE;
            stop_pend  <= 1'b0;
            conv_abort <= conv_busy;
         end else if (cmd.go) begin
            state_q    <= cont_mode ? SEQ_RUN : SEQ_ONE;
            conv_start <= 1'b1;
            conv_abort <= conv_busy;
            stop_pend  <= 1'b0;
         end else if (done_ok) begin
            if (keep_running) begin
               conv_start <= 1'b1;
            end else begin
               state_q   <= SEQ_IDLE;
               stop_pend <= 1'b0;
            end
         end else if (cmd.halt && state_q == SEQ_RUN) begin
            stop_pend <= 1'b1;
         end
      end
   end

   p_key_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.key_rst |=> soft_rst_req && !conv_busy);
   p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.go && !flush) |=> conv_start && conv_busy);
   p_stream_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok && state_q == SEQ_RUN && !stop_pend && !cmd.halt) |=> conv_start && conv_busy);
   p_restart_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.go && conv_busy && !flush) |=> conv_abort);
   p_stop_only_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pend |-> state_q == SEQ_RUN);
   p_pd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> !conv_busy && !conv_start);
endmodule

// File: rtl/conv_seq_tally.sv
module conv_seq_tally #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             done_ok,
   input  logic             result_rd,
   output logic [CNT_W-1:0] count,
   output logic             data_rdy
);
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("counter needs at least two bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= FULL;
         data_rdy <= 1'b0;
      end else if (flush) begin
         count    <= FULL;
         data_rdy <= 1'b0;
      end else begin
         if (done_ok) begin
            count <= count + ONE;
         end
         if (done_ok) begin
            data_rdy <= 1'b1;
         end else if (result_rd) begin
            data_rdy <= 1'b0;
         end
      end
   end

   p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok |=> count == $past(count) + ONE);
   p_flush_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> count == FULL && !data_rdy);
   p_ready_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok |=> data_rdy);
endmodule

// File: rtl/conv_seq.sv
module conv_seq
   import conv_seq_pkg::*;
#(
   parameter int CTRL_W = 8,
   parameter int KEY_W  = 6,
   parameter logic [KEY_W-1:0] KEY = 6'b010110,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_en,
   input  logic [CTRL_W-1:0] ctl_wr_data,
   output logic [CTRL_W-1:0] ctl_rd_data,
   input  logic              cont_mode,
   input  logic              pwr_down,
   input  logic              conv_done,
   input  logic              result_rd,
   output logic              conv_start,
   output logic              conv_busy,
   output logic              conv_abort,
   output logic              soft_rst_req,
   output logic [CNT_W-1:0]  conv_count,
   output logic              data_rdy
);
   seq_cmd_t cmd;
   logic     stop_pend;
   logic     done_ok;
   logic     flush;

   conv_seq_cmd_dec #(.CTRL_W(CTRL_W), .KEY_W(KEY_W), .KEY(KEY)) u_dec (
      .wr_en   (ctl_wr_en),
      .wr_data (ctl_wr_data),
      .cmd     (cmd)
   );

   conv_seq_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd          (cmd),
      .cont_mode    (cont_mode),
      .pwr_down     (pwr_down),
      .conv_done    (conv_done),
      .conv_start   (conv_start),
      .conv_busy    (conv_busy),
      .conv_abort   (conv_abort),
      .soft_rst_req (soft_rst_req),
      .stop_pend    (stop_pend),
      .done_ok      (done_ok),
      .flush        (flush)
   );

   conv_seq_tally #(.CNT_W(CNT_W)) u_tally (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .done_ok   (done_ok),
      .result_rd (result_rd),
      .count     (conv_count),
      .data_rdy  (data_rdy)
   );

   assign ctl_rd_data = {{(CTRL_W-1){1'b0}}, stop_pend};

   p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd_data[0] |-> conv_busy && cont_mode == cont_mode);
endmodule

// File: tb/conv_seq_tb.sv
module conv_seq_tb;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr_en = 1'b0;
   logic [7:0] ctl_wr_data = 8'h00;
   logic [7:0] ctl_rd_data;
   logic       cont_mode = 1'b0;
   logic       pwr_down = 1'b0;
   logic       conv_done = 1'b0;
   logic       result_rd = 1'b0;
   logic       conv_start, conv_busy, conv_abort, soft_rst_req, data_rdy;
   logic [3:0] conv_count;

   always #4 clk = ~clk;

   conv_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
      .ctl_rd_data(ctl_rd_data), .cont_mode(cont_mode), .pwr_down(pwr_down),
      .conv_done(conv_done), .result_rd(result_rd), .conv_start(conv_start),
      .conv_busy(conv_busy), .conv_abort(conv_abort), .soft_rst_req(soft_rst_req),
      .conv_count(conv_count), .data_rdy(data_rdy)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: mode 0 idle, 1 one-shot, 2 streaming
   int m_mode = 0;
   bit m_stop = 0, m_start = 0, m_abort = 0, m_soft = 0, m_rdy = 0;
   int m_cnt = 15;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_stop = 0; m_start = 0; m_abort = 0; m_soft = 0; m_rdy = 0; m_cnt = 15;
      end else begin
         bit busy, is_key, go, halt, fin;
         busy   = (m_mode != 0);
         is_key = ctl_wr_en && (ctl_wr_data == 8'h58);
         go     = ctl_wr_en && ctl_wr_data[1] && !ctl_wr_data[0];
         halt   = ctl_wr_en && ctl_wr_data[0] && !ctl_wr_data[1];
         m_start = 0; m_abort = 0; m_soft = is_key;
         if (is_key || pwr_down) begin
            m_abort = busy; m_mode = 0; m_stop = 0; m_cnt = 15; m_rdy = 0;
         end else if (go) begin
            m_abort = busy; m_start = 1; m_stop = 0; m_mode = cont_mode ? 2 : 1;
            if (result_rd) m_rdy = 0;
         end else begin
            fin = conv_done && busy;
            if (fin) begin
               m_cnt = (m_cnt + 1) % 16; m_rdy = 1;
               if (m_mode == 2 && !m_stop && !halt) m_start = 1;
               else begin m_mode = 0; m_stop = 0; end
            end else begin
               if (halt && m_mode == 2) m_stop = 1;
               if (result_rd) m_rdy = 0;
            end
         end
      end
   end

   int conv_len = 4;
   int tmr = 0;
   bit auto_mod = 1;

   task automatic cyc();
      @(posedge clk);
      #1;
      chk(conv_start == m_start, "R3 conv_start", conv_start, m_start);
      chk(conv_busy == (m_mode != 0), "R3 conv_busy", conv_busy, m_mode != 0);
      chk(conv_abort == m_abort, "R5 conv_abort", conv_abort, m_abort);
      chk(soft_rst_req == m_soft, "R1 soft_rst_req", soft_rst_req, m_soft);
      chk(conv_count == m_cnt, "R9 conv_count", conv_count, m_cnt);
      chk(data_rdy == m_rdy, "R10 data_rdy", data_rdy, m_rdy);
      chk(ctl_rd_data == {7'd0, m_stop}, "R2 readback", ctl_rd_data, m_stop);
      if (auto_mod) begin
         conv_done = 1'b0;
         if (!conv_busy) tmr = 0;
         else if (conv_start) tmr = conv_len;
         if (tmr > 0) begin
            tmr--;
            if (tmr == 0) conv_done = 1'b1;
         end
      end
   endtask

   task automatic wr(input logic [7:0] d);
      ctl_wr_en = 1'b1; ctl_wr_data = d;
      cyc();
      ctl_wr_en = 1'b0; ctl_wr_data = 8'h00;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && conv_busy; i++) cyc();
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc();
      chk(conv_count == 4'hF, "R9 reset count", conv_count, 15);
      chk(data_rdy == 1'b0, "R10 reset ready", data_rdy, 0);
      chk(ctl_rd_data == 8'h00, "R2 reset readback", ctl_rd_data, 0);

      // single shot
      cont_mode = 1'b0;
      wr(8'h02);
      chk(conv_start && conv_busy, "R3 start pulse", conv_start, 1);
      cyc();
      chk(!conv_start, "R3 pulse one wide", conv_start, 0);
      wait_idle();
      chk(conv_count == 4'h0, "R9 first result", conv_count, 0);
      chk(data_rdy == 1'b1, "R10 set on completion", data_rdy, 1);
      result_rd = 1'b1; cyc(); result_rd = 1'b0;
      chk(data_rdy == 1'b0, "R10 cleared by read", data_rdy, 0);

      // continuous with stop
      cont_mode = 1'b1;
      wr(8'h02);
      repeat (18) cyc();
      chk(conv_busy == 1'b1, "R4 stream continues", conv_busy, 1);
      wr(8'h01);
      if (conv_busy) chk(ctl_rd_data[0] == 1'b1, "R7 stop pending", ctl_rd_data[0], 1);
      wait_idle();
      chk(!conv_busy && ctl_rd_data == 8'h00, "R7 stopped after completion", conv_busy, 0);

      // both bits
      wr(8'h03);
      chk(!conv_start && !conv_busy, "R6 both bits ignored", conv_busy, 0);

      // stop in single shot
      cont_mode = 1'b0;
      wr(8'h02);
      wr(8'h01);
      chk(ctl_rd_data[0] == 1'b0, "R7 single-shot stop ignored", ctl_rd_data[0], 0);
      wait_idle();

      // restart clears a pending stop
      cont_mode = 1'b1;
      wr(8'h02);
      cyc();
      wr(8'h01);
      chk(ctl_rd_data[0] == 1'b1, "R7 pending in stream", ctl_rd_data[0], 1);
      wr(8'h02);
      chk(ctl_rd_data[0] == 1'b0, "R8 start clears stop", ctl_rd_data[0], 0);
      chk(conv_abort && conv_start, "R5 restart aborts", conv_abort, 1);
      wr(8'h01);
      wait_idle();

      // wrap
      cont_mode = 1'b0; conv_len = 2;
      base = conv_count;
      for (int k = 0; k < 17; k++) begin
         wr(8'h02);
         wait_idle();
      end
      chk(conv_count == (base + 17) % 16, "R9 wrap", conv_count, (base + 17) % 16);

      // power down
      cont_mode = 1'b1; conv_len = 6;
      wr(8'h02);
      repeat (3) cyc();
      pwr_down = 1'b1;
      cyc();
      chk(!conv_busy && conv_abort, "R11 abort on power-down", conv_busy, 0);
      chk(conv_count == 4'hF && !data_rdy, "R11 counter forced", conv_count, 15);
      wr(8'h02);
      chk(!conv_start && !conv_busy, "R11 start ignored", conv_start, 0);
      pwr_down = 1'b0;
      cyc();

      // keyed reset
      wr(8'h5C);
      chk(!soft_rst_req, "R1 wrong key", soft_rst_req, 0);
      wr(8'h5A);
      chk(!soft_rst_req && conv_busy, "R1 key with start is a start", soft_rst_req, 0);
      repeat (8) cyc();
      wr(8'h58);
      chk(soft_rst_req && !conv_busy && conv_count == 4'hF, "R1 keyed reset", soft_rst_req, 1);
      cyc();
      chk(!soft_rst_req, "R1 one-cycle request", soft_rst_req, 0);

      // collisions
      pwr_down = 1'b1;
      wr(8'h58);
      chk(soft_rst_req == 1'b1, "R12 key beside power-down", soft_rst_req, 1);
      pwr_down = 1'b0;
      auto_mod = 1'b0; conv_done = 1'b0; cont_mode = 1'b0;
      wr(8'h02);
      cyc();
      base = conv_count;
      conv_done = 1'b1;
      wr(8'h02);
      conv_done = 1'b0;
      chk(conv_count == base && conv_abort, "R12 start beats completion", conv_count, base);
      cyc();
      conv_done = 1'b1; result_rd = 1'b1;
      cyc();
      conv_done = 1'b0; result_rd = 1'b0;
      chk(data_rdy == 1'b1, "R10 set wins over read", data_rdy, 1);
      chk(!conv_busy, "R3 single-shot ends", conv_busy, 0);
      auto_mod = 1'b1;
      repeat (3) cyc();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule